// File: doc/BRIEF.md
# Weighted Random Address Stream Generator

This block feeds the lookup tables of stochastic neurons with a fresh 4-bit address on every clock. A 32-bit maximal-length linear feedback shift register supplies random bits in which 0 and 1 are equally likely. One of those bits leaves the block directly as a raw random stream.

Four biasing stages turn the same random source into four streams whose chance of being 1 is set by a fixed 12-bit binary fraction, a different one per address bit. Each stage is a chain of twelve modulator cells. A carrier runs down the chain and is taken by the first cell whose random bit is 1, so cell i is chosen with chance 2^-(i+1). The chosen cell passes on its fraction bit, most significant first, which makes the chance of a 1 equal to the fraction.

The address bus is the four biased streams side by side, so it can take any value from 0 to 15. The register advances 32 steps per clock, so each clock sees a new 32-bit window of the sequence. An output enable gates both outputs.

Top module: `wrand_addr_gen`

## Requirements
- R1: While reset is high at a rising edge, the shift register loads a fixed nonzero seed and both outputs are 0 at the next sample point.
- R2: With enable high, the raw random output is 1 on a fraction of clocks within 0.01 of 0.5, measured over 65536 clocks.
- R3: Address bit 0 is 1 on a fraction of clocks within 0.01 of 0xAA8/4096 (about 0.666).
- R4: Address bit 1 is 1 on a fraction of clocks within 0.01 of 0xCCA/4096 (about 0.799).
- R5: Address bit 2 is 1 on a fraction of clocks within 0.01 of 0xF27/4096 (about 0.947).
- R6: Address bit 3 is 1 on a fraction of clocks within 0.01 of 0xFE8/4096 (about 0.994).
- R7: One clock after enable is sampled low, the address and the raw bit are both 0, and they stay 0 while enable stays low. One clock after enable returns high, the outputs are random again.
- R8: The raw random bit changes value on a fraction of clocks within 0.01 of 0.5.
- R9: The output sequence after reset is released is the same every time, because the seed is fixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oe | input | 1 | Output enable; low forces both outputs to 0 from the next clock |
| rnd_bit | output | 1 | Raw random bit, registered |
| addr | output | 4 | Weighted random address, one biased stream per bit |

## Verification
Most of the run is a long stretch with enable held high. Counting ones per address bit separates the four fraction constants, so a wrong or swapped weight is caught. The same stretch also counts ones and transitions on the raw bit, which shows whether the source is balanced and actually moving. A window with enable low, followed by re-enabling, exercises the gating latency. Two reset releases whose first 64 addresses are compared show that the seeding is deterministic.

// File: rtl/wrand_pkg.sv
package wrand_pkg;
    localparam int LFSR_W   = 32;
    localparam int FRAC_W   = 12;
    localparam int ADDR_W   = 4;
    localparam int STAGE_OFS = 8;
    localparam logic [LFSR_W-1:0] TAP_MASK = 32'h8020_0003;
    localparam logic [LFSR_W-1:0] SEED     = 32'h1ACE_B00C;

    typedef logic [FRAC_W-1:0] frac_t;
    typedef frac_t [ADDR_W-1:0] weight_set_t;

    localparam weight_set_t WEIGHTS = '{12'hFE8, 12'hF27, 12'hCCA, 12'hAA8};

    function automatic logic [LFSR_W-1:0] lfsr_advance(
        input logic [LFSR_W-1:0] s,
        input int unsigned       steps
    );
        logic [LFSR_W-1:0] v;
        v = s;
        for (int unsigned n = 0; n < steps; n++) begin
            v = {v[LFSR_W-2:0], ^(v & TAP_MASK)};
        end
        return v;
    endfunction
endpackage

// File: rtl/wrand_lfsr.sv
module wrand_lfsr
    import wrand_pkg::*;
#(
    parameter int W     = LFSR_W,
    parameter int STEPS = LFSR_W
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] state
);
    always_ff @(posedge clk) begin
        if (rst) state <= SEED;
        else     state <= lfsr_advance(state, STEPS);
    end

    p_seed_nonzero_r1: assert property (@(posedge clk) disable iff (rst)
        state != '0);
    p_state_moves_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> state != $past(state));
endmodule

// File: rtl/wrand_mod_cell.sv
module wrand_mod_cell (
    input  logic carry_in,
    input  logic rnd,
    input  logic wbit,
    output logic carry_out,
    output logic pick,
    output logic contrib
);
    always_comb begin
        pick      = carry_in & rnd;
        carry_out = carry_in & ~rnd;
        contrib   = pick & wbit;
    end
endmodule

// File: rtl/wrand_weight_stage.sv
module wrand_weight_stage
    import wrand_pkg::*;
#(
    parameter int    N      = FRAC_W,
    parameter frac_t WEIGHT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         act,
    input  logic [N-1:0] rnd,
    output logic         bit_q
);
    logic [N:0]   carry;
    logic [N-1:0] picks;
    logic [N-1:0] contribs;

    assign carry[0] = 1'b1;

    for (genvar i = 0; i < N; i++) begin : g_cell
        wrand_mod_cell u_cell (
            .carry_in (carry[i]),
            .rnd      (rnd[i]),
            .wbit     (WEIGHT[N-1-i]),
            .carry_out(carry[i+1]),
            .pick     (picks[i]),
            .contrib  (contribs[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || !act) bit_q <= 1'b0;
        else             bit_q <= |contribs;
    end

    p_single_pick_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(picks));
    p_exhausted_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (act && carry[N]) |=> !bit_q);
endmodule

// File: rtl/wrand_addr_gen.sv
module wrand_addr_gen
    import wrand_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              oe,
    output logic              rnd_bit,
    output logic [ADDR_W-1:0] addr
);
    logic [LFSR_W-1:0] lfsr_state;

    wrand_lfsr #(.W(LFSR_W), .STEPS(LFSR_W)) u_lfsr (
        .clk  (clk),
        .rst  (rst),
        .state(lfsr_state)
    );

    for (genvar k = 0; k < ADDR_W; k++) begin : g_stage
        logic [FRAC_W-1:0] rsel;
        for (genvar i = 0; i < FRAC_W; i++) begin : g_tap
            assign rsel[i] = lfsr_state[(k*STAGE_OFS + i) % LFSR_W];
        end
        wrand_weight_stage #(.N(FRAC_W), .WEIGHT(WEIGHTS[k])) u_stage (
            .clk  (clk),
            .rst  (rst),
            .act  (oe),
            .rnd  (rsel),
            .bit_q(addr[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || !oe) rnd_bit <= 1'b0;
        else            rnd_bit <= lfsr_state[0];
    end

    p_gate_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !oe |=> (addr == '0 && !rnd_bit));
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (addr == '0 && !rnd_bit));
endmodule

// File: tb/wrand_addr_gen_bench.sv
module wrand_addr_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       oe  = 1'b1;
    logic       rnd_bit;
    logic [3:0] addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    wrand_addr_gen u_wrand_addr_gen (
        .clk(clk), .rst(rst), .oe(oe), .rnd_bit(rnd_bit), .addr(addr)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string msg,
                         input real act, input real exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%f expected=%f", req, msg, act, exp);
        end
    endtask

    task automatic check_frac(input int ones, input int total, input int num,
                              input string req, input string msg);
        real f, e;
        f = real'(ones) / real'(total);
        e = real'(num) / 4096.0;
        check((f - e) < 0.01 && (e - f) < 0.01, req, msg, f, e);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        oe  = 1'b1;
        repeat (4) @(negedge clk);
        // R1: outputs zero while reset held
        check(addr == 4'd0, "R1", "addr during reset", real'(addr), 0.0);
        check(rnd_bit == 1'b0, "R1", "rnd_bit during reset", real'(rnd_bit), 0.0);
        rst = 1'b0;
    endtask

    logic [3:0] first_seq [64];

    initial begin
        int n1 [4];
        int nraw, ntog, bad;
        logic prev;
        bit same;

        do_reset();
        for (int c = 0; c < 64; c++) begin
            @(negedge clk);
            first_seq[c] = addr;
        end

        n1 = '{0, 0, 0, 0};
        nraw = 0; ntog = 0;
        prev = rnd_bit;
        for (int c = 0; c < 65536; c++) begin
            @(negedge clk);
            for (int b = 0; b < 4; b++) n1[b] += int'(addr[b]);
            nraw += int'(rnd_bit);
            ntog += int'(rnd_bit != prev);
            prev = rnd_bit;
        end
        check_frac(nraw, 65536, 2048, "R2", "raw bit ones fraction");
        check_frac(n1[0], 65536, 12'hAA8, "R3", "addr[0] ones fraction");
        check_frac(n1[1], 65536, 12'hCCA, "R4", "addr[1] ones fraction");
        check_frac(n1[2], 65536, 12'hF27, "R5", "addr[2] ones fraction");
        check_frac(n1[3], 65536, 12'hFE8, "R6", "addr[3] ones fraction");
        check_frac(ntog, 65536, 2048, "R8", "raw bit toggle fraction");

        // R7: enable low gates outputs one clock later
        oe = 1'b0;
        @(negedge clk);
        bad = 0;
        for (int c = 0; c < 200; c++) begin
            if (addr != 4'd0 || rnd_bit) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R7", "nonzero outputs while disabled", real'(bad), 0.0);
        oe = 1'b1;
        n1[3] = 0;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            n1[3] += int'(addr[3]);
        end
        check(n1[3] >= 12, "R7", "addr[3] ones after re-enable", real'(n1[3]), 16.0);

        // R9: identical sequence after a second reset
        do_reset();
        same = 1;
        for (int c = 0; c < 64; c++) begin
            @(negedge clk);
            if (addr != first_seq[c]) same = 0;
        end
        check(same, "R9", "sequence repeat after reset", real'(same), 1.0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule